// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach PHY management registers over a two-wire serial bus: a clock (MDC) that the block generates, and a bidirectional data line (MDIO) split here into output, output enable and input. Software sees four 32-bit registers, selected by a 2-bit index: configuration/status (0), control (1), data (2) and address (3). Writing the right register launches one management frame. Clause 22 or Clause 45 framing is chosen by a configuration bit.

MDC runs only while a frame is in flight. Its period is an odd number of system clocks. A divider field F in configuration bits 15:8 sets the period. The block either puts each outgoing bit on the wire when MDC falls, or when MDC rises. On reads it lets go of the line for the turnaround, samples the PHY's answer, and flags a PHY that never drove the line low. Software polls busy in either configuration bit 0 or data bit 31.

Top module: `mdio_master`

## Requirements
- R1: With D = 2·max(F,3), the MDC period is 2·D+1 system clocks. MDC is low for the first D+1 clocks of each bit period and high for the last D clocks.
- R2: A frame is sent MSB-first as 32 ones, start code, opcode, 5-bit port, 5-bit device/register, turnaround 10 and 16 data bits. Control bit 10 = 1 drops the 32 ones.
- R3: With configuration bit 6 = 0 (Clause 22) the start code is 01. A data-register write sends opcode 01 carrying wdata[15:0]. A control write with bit 15 = 1 sends opcode 10. The device field carries control bits 4:0 and the port field carries bits 9:5. An address-register write sends no frame.
- R4: With configuration bit 6 = 1 (Clause 45) the start code is 00. An address-register write sends opcode 00 carrying wdata[15:0], a data write sends opcode 01 and a read sends opcode 11.
- R5: With configuration bit 23 = 1, each new bit appears as MDC falls, and bit 0 appears at frame launch. With bit 23 = 0, each bit appears as MDC rises.
- R6: On a read, the output enable is low from the first turnaround bit to the end of the frame. mdio_i is sampled in the clock before each MDC rise. Data bits 15:0 hold the 16 sampled data bits once the frame ends.
- R7: Configuration bit 1 is set when the second turnaround bit of a read samples as 1, and cleared when any frame launches.
- R8: Configuration bit 0 and data bit 31 both read 1 from the clock after the launching write until the last bit period ends, and 0 otherwise.
- R9: A register write that arrives while busy changes no register and launches no frame.
- R10: While idle, MDC and the output enable are both low.
- R11: The fields read back where they were written. Configuration: bits 4:2 (hold setting), 6, 15:8 and 23. Control: bits 10:0, with bit 15 reading 0. Address: bits 15:0.
- R12: After reset every register field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 config, 1 control, 2 data, 3 address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
A wrong divider count or bit position shows up within one MDC period as a misplaced MDC edge or a wrong MDIO level. The reference model compares both every clock. A broken turnaround release shows up on mdio_oe in the first turnaround period. A bad sample point or a lost error flag shows up when the data and configuration registers are read after the frame. A busy flag that drops too early shows up in the very clock where the model still expects 1.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FLD_W    = 5;
  localparam int WORD_W   = 16;
  localparam int HDR_W    = 2 + 2 + FLD_W + FLD_W + 2;
  localparam int BODY_W   = HDR_W + WORD_W;
  localparam int MIN_DIVF = 3;

  localparam logic [1:0] IDX_CFG  = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_DATA = 2'd2;
  localparam logic [1:0] IDX_ADDR = 2'd3;

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_WRITE = 2'd1,
    FK_READ  = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
#(
  parameter int DIVF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIVF_W-1:0] divf,
  output logic              mdc,
  output logic              second_half,
  output logic              rise_tick,
  output logic              period_end
);
  localparam int CNT_W = DIVF_W + 2;

  logic [DIVF_W-1:0] f_eff;
  logic [CNT_W-1:0]  half_cnt;
  logic [CNT_W-1:0]  last_cnt;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    f_eff    = (divf < DIVF_W'(MIN_DIVF)) ? DIVF_W'(MIN_DIVF) : divf;
    half_cnt = {1'b0, f_eff, 1'b0};
    last_cnt = {f_eff, 2'b00};
  end

  always_comb begin
    if (!run || cnt_q == last_cnt) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    second_half = cnt_q > half_cnt;
    mdc         = run && second_half;
    rise_tick   = run && (cnt_q == half_cnt);
    period_end  = run && (cnt_q == last_cnt);
  end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
(
  input  logic              c45,
  input  frame_kind_e       kind,
  input  logic [FLD_W-1:0]  port,
  input  logic [FLD_W-1:0]  dev,
  input  logic [WORD_W-1:0] payload,
  output logic [BODY_W-1:0] body
);
  logic [1:0] st;
  logic [1:0] op;

  always_comb begin
    st = c45 ? 2'b00 : 2'b01;
    unique case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    body = {st, op, port, dev, 2'b10, payload};
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [BODY_W-1:0] body_in,
  input  logic              skip_pre,
  input  logic              is_read,
  input  logic              neg_launch,
  input  logic              second_half,
  input  logic              rise_tick,
  input  logic              period_end,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              ta_valid,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_word
);
  localparam int FRAME_W = PRE_LEN + BODY_W;
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
  localparam logic [POS_W-1:0] TA1_POS  = POS_W'(PRE_LEN + HDR_W - 2);
  localparam logic [POS_W-1:0] TA2_POS  = POS_W'(PRE_LEN + HDR_W - 1);
  localparam logic [POS_W-1:0] DAT_POS  = POS_W'(PRE_LEN + HDR_W);
  localparam logic [POS_W-1:0] PRE_POS  = POS_W'(PRE_LEN);

  logic              busy_q, busy_d;
  logic              read_q, read_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [POS_W-1:0]  start_q, start_d;
  logic [BODY_W-1:0] body_q, body_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [POS_W-1:0]  drv_pos;
  logic [POS_W-1:0]  body_idx;

  always_comb begin
    busy_d  = busy_q;
    read_d  = read_q;
    pos_d   = pos_q;
    start_d = start_q;
    body_d  = body_q;
    sh_d    = sh_q;
    if (launch) begin
      busy_d  = 1'b1;
      read_d  = is_read;
      pos_d   = skip_pre ? PRE_POS : '0;
      start_d = skip_pre ? PRE_POS : '0;
      body_d  = body_in;
    end else if (busy_q && period_end) begin
      if (pos_q == LAST_POS) busy_d = 1'b0;
      else                   pos_d  = pos_q + 1'b1;
    end
    if (busy_q && rise_tick && read_q && pos_q >= DAT_POS)
      sh_d = {sh_q[WORD_W-2:0], mdio_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      read_q  <= 1'b0;
      pos_q   <= '0;
      start_q <= '0;
      body_q  <= '0;
      sh_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      read_q  <= read_d;
      pos_q   <= pos_d;
      start_q <= start_d;
      body_q  <= body_d;
      sh_q    <= sh_d;
    end
  end

  always_comb begin
    if (neg_launch || second_half || pos_q == start_q) drv_pos = pos_q;
    else                                               drv_pos = pos_q - 1'b1;
    body_idx = POS_W'(FRAME_W - 1) - drv_pos;
    if (drv_pos < PRE_POS) mdio_o = 1'b1;
    else                   mdio_o = body_q[body_idx];
    mdio_oe  = busy_q && !(read_q && drv_pos >= TA1_POS);
    busy     = busy_q;
    ta_valid = busy_q && rise_tick && read_q && pos_q == TA2_POS;
    rd_done  = busy_q && period_end && read_q && pos_q == LAST_POS;
    rd_word  = sh_q;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIVF_W  = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [2:0]        hold_q, hold_d;
  logic              c45_q, c45_d;
  logic [DIVF_W-1:0] divf_q, divf_d;
  logic              neg_q, neg_d;
  logic              err_q, err_d;
  logic [FLD_W-1:0]  dev_q, dev_d;
  logic [FLD_W-1:0]  port_q, port_d;
  logic              nopre_q, nopre_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] addr_q, addr_d;

  logic              launch;
  frame_kind_e       kind;
  logic [WORD_W-1:0] payload;
  logic [FLD_W-1:0]  f_port;
  logic [FLD_W-1:0]  f_dev;
  logic              f_nopre;
  logic [BODY_W-1:0] body;

  logic              busy;
  logic              second_half;
  logic              rise_tick;
  logic              period_end;
  logic              ta_valid;
  logic              rd_done;
  logic [WORD_W-1:0] rd_word;

  always_comb begin
    hold_d  = hold_q;
    c45_d   = c45_q;
    divf_d  = divf_q;
    neg_d   = neg_q;
    err_d   = err_q;
    dev_d   = dev_q;
    port_d  = port_q;
    nopre_d = nopre_q;
    data_d  = data_q;
    addr_d  = addr_q;
    launch  = 1'b0;
    kind    = FK_WRITE;
    payload = data_q;
    f_port  = port_q;
    f_dev   = dev_q;
    f_nopre = nopre_q;
    if (reg_we && !busy) begin
      unique case (reg_addr)
        IDX_CFG: begin
          hold_d = reg_wdata[4:2];
          c45_d  = reg_wdata[6];
          divf_d = reg_wdata[8 +: DIVF_W];
          neg_d  = reg_wdata[23];
        end
        IDX_CTRL: begin
          dev_d   = reg_wdata[4:0];
          port_d  = reg_wdata[9:5];
          nopre_d = reg_wdata[10];
          f_dev   = reg_wdata[4:0];
          f_port  = reg_wdata[9:5];
          f_nopre = reg_wdata[10];
          if (reg_wdata[15]) begin
            launch  = 1'b1;
            kind    = FK_READ;
            payload = '1;
          end
        end
        IDX_DATA: begin
          data_d  = reg_wdata[WORD_W-1:0];
          launch  = 1'b1;
          kind    = FK_WRITE;
          payload = reg_wdata[WORD_W-1:0];
        end
        default: begin
          addr_d = reg_wdata[WORD_W-1:0];
          if (c45_q) begin
            launch  = 1'b1;
            kind    = FK_ADDR;
            payload = reg_wdata[WORD_W-1:0];
          end
        end
      endcase
    end
    if (launch)        err_d  = 1'b0;
    else if (ta_valid) err_d  = mdio_i;
    if (rd_done)       data_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      c45_q   <= 1'b0;
      divf_q  <= '0;
      neg_q   <= 1'b0;
      err_q   <= 1'b0;
      dev_q   <= '0;
      port_q  <= '0;
      nopre_q <= 1'b0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      hold_q  <= hold_d;
      c45_q   <= c45_d;
      divf_q  <= divf_d;
      neg_q   <= neg_d;
      err_q   <= err_d;
      dev_q   <= dev_d;
      port_q  <= port_d;
      nopre_q <= nopre_d;
      data_q  <= data_d;
      addr_q  <= addr_d;
    end
  end

  mdio_frame_build u_build (
    .c45     (c45_q),
    .kind    (kind),
    .port    (f_port),
    .dev     (f_dev),
    .payload (payload),
    .body    (body)
  );

  mdio_mdc_gen #(.DIVF_W(DIVF_W)) u_mdc (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (busy),
    .divf        (divf_q),
    .mdc         (mdc),
    .second_half (second_half),
    .rise_tick   (rise_tick),
    .period_end  (period_end)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .body_in     (body),
    .skip_pre    (f_nopre),
    .is_read     (kind == FK_READ),
    .neg_launch  (neg_q),
    .second_half (second_half),
    .rise_tick   (rise_tick),
    .period_end  (period_end),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .ta_valid    (ta_valid),
    .rd_done     (rd_done),
    .rd_word     (rd_word)
  );

  always_comb begin
    unique case (reg_addr)
      IDX_CFG:  reg_rdata = {8'b0, neg_q, 7'b0, 8'(divf_q), 1'b0, c45_q, 1'b0,
                             hold_q, err_q, busy};
      IDX_CTRL: reg_rdata = {21'b0, nopre_q, port_q, dev_q};
      IDX_DATA: reg_rdata = {busy, 15'b0, data_q};
      default:  reg_rdata = {16'b0, addr_q};
    endcase
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        neg,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [43:0] store_word
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[0] == reg_rdata[0] && reg_rdata[0] == busy));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> $stable(store_word));

  // R1
  mdc_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);

  // R5
  fall_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && neg && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)))
      |-> $fell(mdc));

  // R5
  rise_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !neg && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)))
      |-> $rose(mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .neg        (neg_q),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .store_word ({hold_q, c45_q, divf_q, neg_q, dev_q, port_q, nopre_q, addr_q})
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Software-visible mirror kept by the bench
  logic       b_c45 = 0, b_neg = 0, b_nopre = 0;
  logic [7:0] b_divf = 0;
  logic [4:0] b_dev = 0, b_port = 0;

  // Reference model state
  bit mq[$];
  int m_t = 0, m_nb = 0, m_p = 13, m_d = 6;
  bit m_act = 0, m_read = 0, m_neg = 0;

  function automatic void push_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) mq.push_back(v[i]);
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    bit go = 0;
    bit rd = 0;
    logic [1:0] op = 2'b01;
    logic [15:0] pay = 16'hFFFF;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (!m_act) begin
      case (a)
        2'd0: begin b_c45 = d[6]; b_divf = d[15:8]; b_neg = d[23]; end
        2'd1: begin
          b_dev = d[4:0]; b_port = d[9:5]; b_nopre = d[10];
          if (d[15]) begin go = 1; rd = 1; op = b_c45 ? 2'b11 : 2'b10; end
        end
        2'd2: begin go = 1; op = 2'b01; pay = d[15:0]; end
        default: if (b_c45) begin go = 1; op = 2'b00; pay = d[15:0]; end
      endcase
    end
    @(posedge clk);
    #1;
    reg_we = 1'b0; reg_addr = 2'd2;
    if (go) begin
      mq.delete();
      if (!b_nopre) push_bits(32'hFFFFFFFF, 32);
      push_bits({30'b0, (b_c45 ? 2'b00 : 2'b01)}, 2);
      push_bits({30'b0, op}, 2);
      push_bits({27'b0, b_port}, 5);
      push_bits({27'b0, b_dev}, 5);
      push_bits(32'h2, 2);
      push_bits({16'b0, pay}, 16);
      m_nb = mq.size();
      m_d = 2 * ((b_divf < 3) ? 3 : int'(b_divf));
      m_p = 2 * m_d + 1;
      m_neg = b_neg; m_read = rd; m_t = 0; m_act = 1;
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk);
    #1 reg_addr = 2'd2;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (m_act && n < 50000) begin @(posedge clk); n++; end
    repeat (2) @(posedge clk);
  endtask

  // Cycle-by-cycle reference comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int k, c, idx;
      bit eb, emdc, eoe, eo;
      eb = m_act && (m_t < m_nb * m_p);
      k = m_t / m_p; c = m_t % m_p;
      emdc = eb && (c > m_d);
      idx = (m_neg || c > m_d || k == 0) ? k : k - 1;
      eoe = eb && !(m_read && idx >= m_nb - 18);
      eo = (eb && idx < m_nb) ? mq[idx] : 1'b0;
      chk("R1 mdc", {31'b0, mdc}, {31'b0, emdc});
      chk("R6/R10 mdio_oe", {31'b0, mdio_oe}, {31'b0, eoe});
      if (eoe) chk("R2/R5 mdio_o", {31'b0, mdio_o}, {31'b0, eo});
      if (reg_addr == 2'd2) chk("R8 busy data[31]", {31'b0, reg_rdata[31]}, {31'b0, eb});
      if (reg_addr == 2'd0) chk("R8 busy cfg[0]", {31'b0, reg_rdata[0]}, {31'b0, eb});
      if (m_act) begin
        if (m_t >= m_nb * m_p) m_act = 0;
        else m_t++;
      end
    end
  end

  // Behavioural PHY responder at port 4; samples on MDC rise, drives after MDC fall
  localparam logic [4:0] PHY_PORT = 5'd4;
  logic [15:0] phy_mem [int];
  logic [15:0] phy_ptr [int];
  bit          p_prev = 0, p_in = 0, p_go = 0, p_me = 0;
  int          p_cnt = 0, p_fc = 0;
  logic [31:0] p_sh = '0;
  logic [1:0]  p_st, p_op;
  logic [4:0]  p_dev;
  logic [15:0] p_resp;

  function automatic int phy_key(input logic st, input logic [4:0] dev);
    logic [15:0] ptr;
    ptr = phy_ptr.exists(int'(dev)) ? phy_ptr[int'(dev)] : 16'h0;
    return st ? int'(dev) : (32'h0100_0000 | (int'(dev) << 16) | int'(ptr));
  endfunction

  function automatic logic [15:0] phy_get(input int key);
    return phy_mem.exists(key) ? phy_mem[key] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      p_prev = 0; p_in = 0; p_go = 0; mdio_i = 1'b1;
    end else begin
      if (mdc && !p_prev) begin
        logic b;
        b = mdio_oe ? mdio_o : mdio_i;
        if (!p_in) begin
          if (mdio_oe && !mdio_o) begin p_in = 1; p_cnt = 1; p_sh = '0; end
        end else begin
          p_sh = {p_sh[30:0], b};
          p_cnt++;
          if (p_cnt == 14) begin
            p_st = p_sh[13:12]; p_op = p_sh[11:10]; p_dev = p_sh[4:0];
            p_me = (p_sh[9:5] == PHY_PORT);
            if (p_me && (p_op == 2'b10 || p_op == 2'b11)) begin
              p_resp = phy_get(phy_key(p_st[0], p_dev));
              p_go = 1; p_fc = 0;
            end
          end
          if (p_cnt == 32) begin
            if (p_me && p_op == 2'b01) phy_mem[phy_key(p_st[0], p_dev)] = p_sh[15:0];
            if (p_me && p_op == 2'b00 && p_st == 2'b00) phy_ptr[int'(p_dev)] = p_sh[15:0];
            p_in = 0;
          end
        end
      end
      if (!mdc && p_prev && p_go) begin
        p_fc++;
        if (p_fc == 1) mdio_i = 1'b1;
        else if (p_fc == 2) mdio_i = 1'b0;
        else if (p_fc <= 18) mdio_i = p_resp[18 - p_fc];
        else begin mdio_i = 1'b1; p_go = 0; end
      end
      p_prev = mdc;
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state, R10 idle outputs
    reg_read(2'd0, v); chk("R12 cfg reset", v, 32'h0);
    reg_read(2'd1, v); chk("R12 ctrl reset", v, 32'h0);
    reg_read(2'd2, v); chk("R12 data reset", v, 32'h0);
    reg_read(2'd3, v); chk("R12 addr reset", v, 32'h0);
    chk("R10 idle mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);

    // R11 readback of configuration fields
    reg_write(2'd0, 32'h00800314);
    reg_read(2'd0, v); chk("R11 cfg readback", v, 32'h00800314);

    // R3 Clause 22 write frame, falling-edge launch
    reg_write(2'd1, 32'h00000085);
    reg_read(2'd1, v); chk("R11 ctrl readback", v, 32'h00000085);
    reg_write(2'd2, 32'h00001234);
    reg_read(2'd0, v); chk("R8 busy after launch", {31'b0, v[0]}, 32'h1);
    // R9 writes while busy ignored
    reg_write(2'd0, 32'h0);
    reg_write(2'd1, 32'h00000000);
    wait_idle();
    reg_read(2'd0, v); chk("R9 cfg untouched", v, 32'h00800314);
    reg_read(2'd1, v); chk("R9 ctrl untouched", v, 32'h00000085);
    chk("R3 phy got c22 write", {16'b0, phy_get(5)}, 32'h1234);
    chk("R10 idle mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);

    // R6 Clause 22 read back
    reg_write(2'd1, 32'h00008085);
    wait_idle();
    reg_read(2'd2, v); chk("R6 read data", v, 32'h00001234);
    reg_read(2'd0, v); chk("R7 no error", {31'b0, v[1]}, 32'h0);

    // R7 read from an absent port
    reg_write(2'd1, 32'h00008125);
    wait_idle();
    reg_read(2'd2, v); chk("R6 absent data", v, 32'h0000FFFF);
    reg_read(2'd0, v); chk("R7 error set", {31'b0, v[1]}, 32'h1);

    // R3 address register in Clause 22 sends nothing; R7 cleared at launch
    reg_write(2'd3, 32'h00000ABC);
    reg_read(2'd2, v); chk("R3 no frame from addr", {31'b0, v[31]}, 32'h0);
    reg_read(2'd3, v); chk("R11 addr readback", v, 32'h00000ABC);
    reg_write(2'd1, 32'h00000085);
    reg_write(2'd2, 32'h00001234);
    reg_read(2'd0, v); chk("R7 cleared on launch", {30'b0, v[1:0]}, 32'h1);
    wait_idle();

    // R4 Clause 45 address, write, read
    reg_write(2'd0, 32'h00800354);
    reg_write(2'd1, 32'h00000081);
    reg_write(2'd3, 32'h00000170);
    wait_idle();
    chk("R4 phy pointer", {16'b0, phy_ptr[1]}, 32'h0170);
    reg_write(2'd2, 32'h0000BEEF);
    wait_idle();
    chk("R4 phy got c45 write", {16'b0, phy_get(32'h0101_0170)}, 32'hBEEF);
    reg_write(2'd2, 32'h00000000);
    wait_idle();
    reg_write(2'd1, 32'h00008081);
    wait_idle();
    reg_read(2'd2, v); chk("R4 c45 read", v, 32'h00000000);
    reg_write(2'd2, 32'h0000BEEF);
    wait_idle();
    reg_write(2'd1, 32'h00008081);
    wait_idle();
    reg_read(2'd2, v); chk("R4 c45 read back", v, 32'h0000BEEF);

    // R2 preamble suppressed, R5 rising-edge launch, F=5
    reg_write(2'd0, 32'h00000500);
    reg_write(2'd1, 32'h00000485);
    reg_write(2'd2, 32'h00005A5A);
    wait_idle();
    chk("R2 phy got no-preamble write", {16'b0, phy_get(5)}, 32'h5A5A);
    reg_write(2'd1, 32'h00008485);
    wait_idle();
    reg_read(2'd2, v); chk("R5 read in rising mode", v, 32'h00005A5A);

    // R1 divider clamp at F=1
    reg_write(2'd0, 32'h00000100);
    reg_write(2'd2, 32'h000000FF);
    wait_idle();
    chk("R1 phy got clamped-divider write", {16'b0, phy_get(5)}, 32'h00FF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule